// File: doc/BRIEF.md
# Cycle-Counting Overflow Interrupt Timer

This block raises an interrupt once a set number of processor cycles has gone by. Software places a 16-bit start value into a reload latch, one byte per write. A write to the control address copies the latch into a 17-bit up-counter and chooses whether counting begins. While counting is on, the counter gains one on every clock. The interrupt rises when the counter carries into bit 16, so the delay in cycles is 0x10000 minus the start value.

The interrupt is sticky. Only a write to the acknowledge address or to the control address clears it. An acknowledge also loads the enable from a re-arm bit, which was stored by the last control write. The counter is never reloaded by the hardware. If counting is re-enabled after an overflow, bit 16 is still set, so the interrupt rises again on the next cycle. The counter keeps running until it wraps at 17 bits.

Top module: `ovf_irq_timer`

## Requirements
- R1: A write to 0xD600 replaces bits 7:0 of the reload latch, and a write to 0xD700 replaces bits 15:8. The other byte keeps its value.
- R2: A write to 0xD900 loads the counter with the latch value (bit 16 cleared) and clears the interrupt. It sets the enable from data bit 1 and stores data bit 0 as the re-arm flag.
- R3: While enabled, the counter gains one per clock. The interrupt is high after the edge on which the counter reaches 0x10000, which is 0x10000 minus the start value edges after the loading edge.
- R4: While disabled, the counter holds its value and no interrupt is raised.
- R5: Once high, the interrupt stays high until a write to 0xD800 or 0xD900. Writes to the latch addresses do not clear it.
- R6: A write to 0xD800 clears the interrupt and copies the re-arm flag into the enable. Data bits are not used.
- R7: The counter is not reloaded after an overflow. After an acknowledge with re-arm set, the interrupt rises again on the next edge while bit 16 is still set.
- R8: The counter wraps from 0x1FFFF to 0, and that step raises no interrupt.
- R9: When an acknowledge or control write falls on the same edge as an overflow step, the clear wins. During an acknowledge the counter still advances under the old enable.
- R10: Writes to any other address, including addresses near the four decoded ones, have no effect.
- R11: Reset clears the latch, the counter, the enable, the re-arm flag and the interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock; one count per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | 16 | Write address |
| wdata | input | 8 | Write data byte |
| irq | output | 1 | Active-high interrupt request |

## Verification
Clearing the interrupt and setting it on overflow can fall in the same cycle. The bench loads 0xFFFD with counting on, then times an acknowledge so that it lands on the third edge, the one that carries into bit 16. With re-arm clear, the interrupt must be low after that edge and must stay low. With re-arm set, it must be low after that edge and high one edge later. This shows that the clear won and that the counter still stepped under the old enable.

// File: rtl/ovf_timer_pkg.sv
package ovf_timer_pkg;
   typedef enum logic [1:0] {
      TOP_IDLE  = 2'd0,
      TOP_LATCH = 2'd1,
      TOP_ACK   = 2'd2,
      TOP_CTRL  = 2'd3
   } tmr_op_e;
endpackage

// File: rtl/ovf_timer_decode.sv
module ovf_timer_decode
   import ovf_timer_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int LANES = 2,
   parameter logic [ADDR_W-1:0] LATCH_BASE = 16'hD600,
   parameter logic [ADDR_W-1:0] LANE_STRIDE = 16'h0100,
   parameter logic [ADDR_W-1:0] ACK_ADDR = 16'hD800,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hD900
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   output tmr_op_e           op,
   output logic [LANES-1:0]  lane_we
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam logic [ADDR_W-1:0] LANE_ADDR =
         ADDR_W'(int'(LATCH_BASE) + g * int'(LANE_STRIDE));
      assign lane_we[g] = wr_en && (addr == LANE_ADDR);
   end

   always_comb begin
      op = TOP_IDLE;
      if (wr_en) begin
         if (addr == CTRL_ADDR)      op = TOP_CTRL;
         else if (addr == ACK_ADDR)  op = TOP_ACK;
         else if (|lane_we)          op = TOP_LATCH;
      end
   end
endmodule

// File: rtl/ovf_timer_latch.sv
module ovf_timer_latch #(
   parameter int DATA_W = 8,
   parameter int LANES = 2,
   localparam int LATCH_W = DATA_W * LANES
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [LANES-1:0]   lane_we,
   input  logic [DATA_W-1:0]  wdata,
   output logic [LATCH_W-1:0] latch
);
   for (genvar g = 0; g < LANES; g++) begin : g_byte
      logic [DATA_W-1:0] byte_q;
      always_ff @(posedge clk) begin
         if (rst)             byte_q <= '0;
         else if (lane_we[g]) byte_q <= wdata;
      end
      assign latch[g*DATA_W +: DATA_W] = byte_q;
   end
endmodule

// File: rtl/ovf_timer_count.sv
module ovf_timer_count #(
   parameter int LATCH_W = 16,
   localparam int CNT_W = LATCH_W + 1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               ctrl_wr,
   input  logic               ack_wr,
   input  logic               en_in,
   input  logic               rearm_in,
   input  logic [LATCH_W-1:0] latch,
   output logic [CNT_W-1:0]   cnt_q,
   output logic               en_q,
   output logic               rearm_q,
   output logic               carry_set
);
   logic [CNT_W-1:0] inc;

   assign inc       = cnt_q + CNT_W'(1);
   assign carry_set = en_q && !ctrl_wr && inc[CNT_W-1];

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q   <= '0;
         en_q    <= 1'b0;
         rearm_q <= 1'b0;
      end else if (ctrl_wr) begin
         cnt_q   <= {1'b0, latch};
         en_q    <= en_in;
         rearm_q <= rearm_in;
      end else begin
         if (en_q)   cnt_q <= inc;
         if (ack_wr) en_q  <= rearm_q;
      end
   end
endmodule

// File: rtl/ovf_timer_flag.sv
module ovf_timer_flag #(
   parameter bit CLEAR_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic set,
   output logic irq
);
   if (CLEAR_WINS) begin : g_clear_first
      always_ff @(posedge clk) begin
         if (rst || clr) irq <= 1'b0;
         else if (set)   irq <= 1'b1;
      end
   end else begin : g_set_first
      always_ff @(posedge clk) begin
         if (rst)      irq <= 1'b0;
         else if (set) irq <= 1'b1;
         else if (clr) irq <= 1'b0;
      end
   end
endmodule

// File: rtl/ovf_irq_timer.sv
module ovf_irq_timer
   import ovf_timer_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int LATCH_W = 16,
   parameter logic [ADDR_W-1:0] LATCH_BASE = 16'hD600,
   parameter logic [ADDR_W-1:0] LANE_STRIDE = 16'h0100,
   parameter logic [ADDR_W-1:0] ACK_ADDR = 16'hD800,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hD900,
   parameter int EN_BIT = 1,
   parameter int REARM_BIT = 0,
   parameter bit CLEAR_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              irq
);
   localparam int LANES = LATCH_W / DATA_W;
   localparam int CNT_W = LATCH_W + 1;

   if (LATCH_W % DATA_W != 0 || LANES < 1) begin : g_bad_width
      $error("latch width must be a whole number of data bytes");
   end
   if (EN_BIT >= DATA_W || REARM_BIT >= DATA_W || EN_BIT == REARM_BIT) begin : g_bad_bits
      $error("control bit positions must be distinct and inside the data byte");
   end
   if (ACK_ADDR == CTRL_ADDR) begin : g_bad_addr
      $error("acknowledge and control addresses must differ");
   end

   tmr_op_e            op;
   logic [LANES-1:0]   lane_we;
   logic [LATCH_W-1:0] latch;
   logic [CNT_W-1:0]   cnt_q;
   logic               en_q;
   logic               rearm_q;
   logic               carry_set;
   logic               ctrl_wr;
   logic               ack_wr;

   assign ctrl_wr = (op == TOP_CTRL);
   assign ack_wr  = (op == TOP_ACK);

   ovf_timer_decode #(
      .ADDR_W(ADDR_W), .LANES(LANES), .LATCH_BASE(LATCH_BASE),
      .LANE_STRIDE(LANE_STRIDE), .ACK_ADDR(ACK_ADDR), .CTRL_ADDR(CTRL_ADDR)
   ) u_decode (
      .wr_en(wr_en), .addr(addr), .op(op), .lane_we(lane_we)
   );

   ovf_timer_latch #(.DATA_W(DATA_W), .LANES(LANES)) u_latch (
      .clk(clk), .rst(rst), .lane_we(lane_we), .wdata(wdata), .latch(latch)
   );

   ovf_timer_count #(.LATCH_W(LATCH_W)) u_count (
      .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ack_wr(ack_wr),
      .en_in(wdata[EN_BIT]), .rearm_in(wdata[REARM_BIT]), .latch(latch),
      .cnt_q(cnt_q), .en_q(en_q), .rearm_q(rearm_q), .carry_set(carry_set)
   );

   ovf_timer_flag #(.CLEAR_WINS(CLEAR_WINS)) u_flag (
      .clk(clk), .rst(rst), .clr(ctrl_wr || ack_wr), .set(carry_set), .irq(irq)
   );
endmodule

// File: rtl/ovf_irq_timer_chk.sv
module ovf_irq_timer_chk #(
   parameter int ADDR_W = 16,
   parameter int LATCH_W = 16,
   parameter logic [ADDR_W-1:0] ACK_ADDR = 16'hD800,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hD900,
   parameter bit CLEAR_WINS = 1'b1,
   localparam int CNT_W = LATCH_W + 1
) (
   input logic               clk,
   input logic               rst,
   input logic               wr_en,
   input logic [ADDR_W-1:0]  addr,
   input logic               irq,
   input logic [CNT_W-1:0]   cnt_q,
   input logic               en_q,
   input logic               rearm_q,
   input logic [LATCH_W-1:0] latch
);
   logic hit_ctrl, hit_ack;
   assign hit_ctrl = wr_en && (addr == CTRL_ADDR);
   assign hit_ack  = wr_en && (addr == ACK_ADDR);

   assert_ctrl_loads_R2: assert property (@(posedge clk) disable iff (rst)
      hit_ctrl |=> cnt_q == {1'b0, $past(latch)});

   assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
      (en_q && !hit_ctrl) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

   assert_hold_disabled_R4: assert property (@(posedge clk) disable iff (rst)
      (!en_q && !hit_ctrl) |=> $stable(cnt_q));

   assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (rst)
      (irq && !hit_ctrl && !hit_ack) |=> irq);

   assert_ack_rearm_R6: assert property (@(posedge clk) disable iff (rst)
      hit_ack |=> en_q == $past(rearm_q));

   assert_rise_on_carry_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(irq) |-> cnt_q[CNT_W-1]);

   if (CLEAR_WINS) begin : g_clear_checks
      assert_clear_wins_R9: assert property (@(posedge clk) disable iff (rst)
         (hit_ack || hit_ctrl) |=> !irq);
   end
endmodule

bind ovf_irq_timer ovf_irq_timer_chk #(
   .ADDR_W(ADDR_W), .LATCH_W(LATCH_W), .ACK_ADDR(ACK_ADDR),
   .CTRL_ADDR(CTRL_ADDR), .CLEAR_WINS(CLEAR_WINS)
) u_chk (
   .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .irq(irq),
   .cnt_q(cnt_q), .en_q(en_q), .rearm_q(rearm_q), .latch(latch)
);

// File: tb/tb_ovf_irq_timer.sv
`timescale 1ns/1ps
module tb_ovf_irq_timer;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [15:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic        irq;
   int          n_chk = 0;
   int          n_fail = 0;

   ovf_irq_timer dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .irq(irq)
   );

   always #2.5 clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; addr = '0; wdata = '0;
   endtask

   task automatic set_latch(input int v);
      wr(16'hD600, v[7:0]);
      wr(16'hD700, v[15:8]);
   endtask

   task automatic wait_irq(input int lim, output int n);
      n = 0;
      for (int i = 1; i <= lim; i++) begin
         @(negedge clk);
         if (irq) begin n = i; break; end
      end
   endtask

   task automatic stays_low(input string tag, input int cycles);
      int seen = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (irq) seen = 1;
      end
      chk(tag, seen, 0);
   endtask

   task automatic summary;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R3 watchdog actual=timeout expected=done");
      summary();
      $finish;
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk("R11 irq after reset", int'(irq), 0);
      stays_low("R11 idle after reset", 20);

      // R1/R3: sweep start values near the top
      for (int k = 1; k <= 24; k++) begin
         set_latch(32'h10000 - k);
         wr(16'hD900, 8'h02);
         wait_irq(64, n);
         chk($sformatf("R3 delay for start %0h", 32'h10000 - k), n, k);
      end

      // R1: low byte only rewrite keeps high byte
      set_latch(16'hFFF8);
      wr(16'hD600, 8'hFC);
      wr(16'hD900, 8'h02);
      wait_irq(300, n);
      chk("R1 low byte rewrite", n, 4);
      wr(16'hD700, 8'hFF);
      wr(16'hD600, 8'hE0);
      wr(16'hD900, 8'h02);
      wait_irq(300, n);
      chk("R1 both bytes", n, 32);

      // R5: sticky, latch writes do not clear, R2 control write clears
      stays_low("R5 placeholder", 0);
      repeat (30) @(negedge clk);
      chk("R5 sticky after idle", int'(irq), 1);
      wr(16'hD600, 8'h55);
      chk("R5 latch write keeps irq", int'(irq), 1);
      wr(16'hD880, 8'h00);
      chk("R10 near ack address ignored", int'(irq), 1);
      set_latch(16'hFFF0);
      wr(16'hD900, 8'h01);
      chk("R2 control write clears irq", int'(irq), 0);

      // R4: disabled holds, R6 ack enables from re-arm flag
      stays_low("R4 disabled no irq", 40);
      wr(16'hD800, 8'h00);
      wait_irq(64, n);
      chk("R4 count held while disabled", n, 16);

      // R7: ack with re-arm set re-raises next edge
      wr(16'hD800, 8'h00);
      chk("R6 ack clears irq", int'(irq), 0);
      @(negedge clk);
      chk("R7 re-raise without reload", int'(irq), 1);

      // R6: ack with re-arm clear stops counting
      set_latch(16'hFFFE);
      wr(16'hD900, 8'h02);
      wait_irq(16, n);
      chk("R2 enable from bit 1", n, 2);
      wr(16'hD800, 8'hFF);
      chk("R6 ack clears irq again", int'(irq), 0);
      stays_low("R6 re-arm clear disables", 30);

      // R10: writes to other addresses leave latch and counter alone
      set_latch(16'hFFF8);
      wr(16'hD500, 8'h00);
      wr(16'hDA00, 8'h03);
      wr(16'hD601, 8'h00);
      wr(16'hD701, 8'h00);
      wr(16'hD900, 8'h02);
      wait_irq(64, n);
      chk("R10 other addresses ignored", n, 8);

      // R9: collision, re-arm clear
      set_latch(16'hFFFD);
      wr(16'hD900, 8'h02);
      repeat (2) @(negedge clk);
      wr(16'hD800, 8'h00);
      chk("R9 clear wins on overflow edge", int'(irq), 0);
      stays_low("R9 stays low after collision", 12);

      // R9: collision, re-arm set
      wr(16'hD900, 8'h03);
      wr(16'hD900, 8'h03);
      set_latch(16'hFFFD);
      wr(16'hD900, 8'h03);
      repeat (2) @(negedge clk);
      wr(16'hD800, 8'h00);
      chk("R9 clear wins with re-arm", int'(irq), 0);
      @(negedge clk);
      chk("R9 counter advanced during ack", int'(irq), 1);

      // R8: wrap from 0x1FFFF to 0 raises nothing
      set_latch(16'hFFFF);
      wr(16'hD900, 8'h03);
      repeat (32'hFFFF) @(negedge clk);
      chk("R3 irq before wrap", int'(irq), 1);
      wr(16'hD800, 8'h00);
      chk("R8 ack at top", int'(irq), 0);
      stays_low("R8 wrap raises nothing", 20);

      // R11: reset mid-operation clears latch and flag
      set_latch(16'hFFFF);
      wr(16'hD900, 8'h03);
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      chk("R11 irq cleared by reset", int'(irq), 0);
      stays_low("R11 enable cleared", 20);
      wr(16'hD700, 8'hFF);
      wr(16'hD900, 8'h02);
      wait_irq(400, n);
      chk("R11 low byte cleared", n, 256);

      summary();
      $finish;
   end
endmodule